// File: doc/BRIEF.md
# Four-Phase Interleave and Conversion Trigger Sequencer

This block produces the timing for four interleaved converter phases from a single free-running period counter. Each phase gets a one-clock turn-on strobe, a one-clock turn-off strobe at the maximum duty point, and a level window that blanks that phase's current comparator just after turn-on. Each phase's timing is shifted from the one before it by a quarter of the period.

For sampling, the block raises a one-clock conversion trigger for each phase a programmable number of clocks before that phase's cycle ends. The sample point therefore steps forward by a quarter period each time. A 2-bit channel index tells the converter which phase's output voltage to sample. The four triggers are also merged into a single start pulse. The period, maximum duty, blanking length and trigger lead come in on configuration inputs. They are captured once when the sequencer starts and again at each counter wrap, so each period runs with one consistent set of values.

Top module: `interleave_seq`

## Requirements
- R1: While reset is asserted, every strobe, window and trigger output is low and `adcChan` is 0. The first clock edge after reset is released captures the configuration. On the next cycle the count is 0 and only `phaseOn[0]` is high.
- R2: The count runs 0 to P-1 and then returns to 0, where P is the captured period. `phaseOn[0]` pulses once every P clocks.
- R3: Let Q = floor(P/4). `phaseOn[k]` is high for exactly one clock, when the count equals k*Q, for k = 0..3.
- R4: `phaseOff[k]` is high for one clock when (count - k*Q) mod P equals the captured maximum duty D. D must be less than P.
- R5: `blankWin[k]` is high while (count - k*Q) mod P is less than the captured blanking length B. The window therefore starts on the turn-on cycle and lasts B clocks, and B = 0 gives no window.
- R6: `adcTrig[k]` is high for one clock when (count - k*Q) mod P equals P - L, where L is the captured lead, 1 <= L <= P.
- R7: `adcTrigAny` is the OR of the four `adcTrig` bits in the same cycle.
- R8: In any cycle where a trigger is high, `adcChan` carries the binary index k of that phase (phase 0 = 2'b00, phase 3 = 2'b11), and the lowest index wins if two coincide. In cycles with no trigger, `adcChan` holds its previous value.
- R9: All phase offsets wrap modulo P. A phase whose on-time crosses the counter wrap turns off D clocks after it turned on.
- R10: The configuration inputs take effect only when the count returns to 0. A change made mid-period leaves the current period length and all its strobe positions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPeriod | input | CNT_W | Period length P in clocks (at least 8) |
| cfgMaxDuty | input | CNT_W | Maximum on-time D in clocks |
| cfgBlank | input | CNT_W | Blanking window length B in clocks |
| cfgLead | input | CNT_W | Trigger lead L before the end of a phase's cycle |
| phaseOn | output | 4 | Per-phase turn-on strobes |
| phaseOff | output | 4 | Per-phase turn-off strobes at maximum duty |
| blankWin | output | 4 | Per-phase comparator blanking windows |
| adcTrig | output | 4 | Per-phase conversion triggers |
| adcTrigAny | output | 1 | OR of all conversion triggers |
| adcChan | output | 2 | Index of the phase to sample |

## Verification
All outputs decode directly from the counter and the captured configuration. A wrong count or a stale offset therefore moves a strobe or trigger in the very cycle it occurs, and a bench that compares every output every cycle against its own counter model catches it within one period. A configuration captured at the wrong moment changes the spacing between turn-on pulses within one period. A channel index that is not held shows up as a changing `adcChan` in a cycle with no trigger. Directed interval measurements check period length, late capture of configuration, and turn-off across the wrap.

// File: rtl/il4_pkg.sv
package il4_pkg;
  localparam int NUM_PH = 4;
  localparam int CH_W   = $clog2(NUM_PH);

  typedef struct packed {
    logic run;
    logic wrap;
  } seqStrb_t;
endpackage

// File: rtl/il4_ctrl.sv
module il4_ctrl
  import il4_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgMaxDuty,
  input  logic [CNT_W-1:0] cfgBlank,
  input  logic [CNT_W-1:0] cfgLead,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] perQ,
  output logic [CNT_W-1:0] dutyQ,
  output logic [CNT_W-1:0] blankQ,
  output logic [CNT_W-1:0] leadQ,
  output logic [CNT_W-1:0] quarterQ,
  output seqStrb_t         strb
);
  logic runQ;
  logic wrap;
  logic load;

  assign wrap = runQ && (cnt == perQ - 1'b1);
  assign load = !runQ || wrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      cnt      <= '0;
      perQ     <= '0;
      dutyQ    <= '0;
      blankQ   <= '0;
      leadQ    <= '0;
      quarterQ <= '0;
    end else begin
      runQ <= 1'b1;
      if (load) begin
        perQ     <= cfgPeriod;
        dutyQ    <= cfgMaxDuty;
        blankQ   <= cfgBlank;
        leadQ    <= cfgLead;
        quarterQ <= cfgPeriod >> 2;
      end
      if (wrap)      cnt <= '0;
      else if (runQ) cnt <= cnt + 1'b1;
    end
  end

  assign strb.run  = runQ;
  assign strb.wrap = wrap;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> (cnt < perQ));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrap |=> (cnt == '0));

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !wrap) |=> ($stable(perQ) && $stable(dutyQ) &&
                         $stable(blankQ) && $stable(leadQ)));
endmodule

// File: rtl/il4_phase_cmp.sv
module il4_phase_cmp #(
  parameter int CNT_W = 10
) (
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] offset,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] blank,
  input  logic [CNT_W-1:0] lead,
  output logic             onStb,
  output logic             offStb,
  output logic             blankOn,
  output logic             trigStb
);
  logic [CNT_W-1:0] rel;
  logic [CNT_W-1:0] trigPt;

  // position within this phase's own cycle, modulo the period
  always_comb begin
    if (cnt >= offset) rel = cnt - offset;
    else               rel = cnt + (per - offset);
  end

  assign trigPt  = per - lead;
  assign onStb   = run && (rel == '0);
  assign offStb  = run && (rel == duty);
  assign blankOn = run && (rel < blank);
  assign trigStb = run && (rel == trigPt);
endmodule

// File: rtl/il4_datapath.sv
module il4_datapath
  import il4_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  perQ,
  input  logic [CNT_W-1:0]  dutyQ,
  input  logic [CNT_W-1:0]  blankQ,
  input  logic [CNT_W-1:0]  leadQ,
  input  logic [CNT_W-1:0]  quarterQ,
  output logic [NUM_PH-1:0] phaseOn,
  output logic [NUM_PH-1:0] phaseOff,
  output logic [NUM_PH-1:0] blankWin,
  output logic [NUM_PH-1:0] adcTrig,
  output logic              adcTrigAny,
  output logic [CH_W-1:0]   adcChan
);
  logic [CNT_W-1:0] offs [NUM_PH];
  logic [CH_W-1:0]  chanNow;
  logic [CH_W-1:0]  lastChan;

  for (genvar k = 0; k < NUM_PH; k++) begin : g_phase
    assign offs[k] = CNT_W'(k) * quarterQ;
    il4_phase_cmp #(.CNT_W(CNT_W)) u_cmp (
      .run     (strb.run),
      .cnt     (cnt),
      .per     (perQ),
      .offset  (offs[k]),
      .duty    (dutyQ),
      .blank   (blankQ),
      .lead    (leadQ),
      .onStb   (phaseOn[k]),
      .offStb  (phaseOff[k]),
      .blankOn (blankWin[k]),
      .trigStb (adcTrig[k])
    );
  end

  // lowest active trigger index wins
  always_comb begin
    chanNow = '0;
    for (int k = NUM_PH - 1; k >= 0; k--) begin
      if (adcTrig[k]) chanNow = CH_W'(k);
    end
  end

  assign adcTrigAny = |adcTrig;
  assign adcChan    = adcTrigAny ? chanNow : lastChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           lastChan <= '0;
    else if (adcTrigAny) lastChan <= chanNow;
  end

  // R3
  on_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseOn));

  // R2
  wrap_on0_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> phaseOn[0]);

  // R6
  trig_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(adcTrig));

  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adcTrigAny |-> $stable(adcChan));
endmodule

// File: rtl/interleave_seq.sv
module interleave_seq
  import il4_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgMaxDuty,
  input  logic [CNT_W-1:0] cfgBlank,
  input  logic [CNT_W-1:0] cfgLead,
  output logic [3:0]       phaseOn,
  output logic [3:0]       phaseOff,
  output logic [3:0]       blankWin,
  output logic [3:0]       adcTrig,
  output logic             adcTrigAny,
  output logic [1:0]       adcChan
);
  logic [CNT_W-1:0] cnt, perQ, dutyQ, blankQ, leadQ, quarterQ;
  seqStrb_t         strb;

  il4_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgPeriod  (cfgPeriod),
    .cfgMaxDuty (cfgMaxDuty),
    .cfgBlank   (cfgBlank),
    .cfgLead    (cfgLead),
    .cnt        (cnt),
    .perQ       (perQ),
    .dutyQ      (dutyQ),
    .blankQ     (blankQ),
    .leadQ      (leadQ),
    .quarterQ   (quarterQ),
    .strb       (strb)
  );

  il4_datapath #(.CNT_W(CNT_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cnt        (cnt),
    .perQ       (perQ),
    .dutyQ      (dutyQ),
    .blankQ     (blankQ),
    .leadQ      (leadQ),
    .quarterQ   (quarterQ),
    .phaseOn    (phaseOn),
    .phaseOff   (phaseOff),
    .blankWin   (blankWin),
    .adcTrig    (adcTrig),
    .adcTrigAny (adcTrigAny),
    .adcChan    (adcChan)
  );
endmodule

// File: tb/interleave_seq_bench.sv
module interleave_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  typedef struct packed {
    int p; int d; int b; int l; int n;
  } vec_t;

  // period, duty, blank, lead, cycles to run
  localparam vec_t VECS [6] = '{
    '{40, 10,  4,  3, 120},
    '{40, 35,  6,  1, 120},
    '{64, 20,  0, 64, 150},
    '{48, 47, 48, 20, 150},
    '{32,  1,  1, 32, 100},
    '{ 8,  3,  2,  2,  40}
  };

  logic clk = 1'b0;
  logic rstN;
  logic [CW-1:0] cfgPeriod, cfgMaxDuty, cfgBlank, cfgLead;
  logic [3:0] phaseOn, phaseOff, blankWin, adcTrig;
  logic adcTrigAny;
  logic [1:0] adcChan;

  always #(CLK_PERIOD/2) clk = ~clk;

  interleave_seq #(.CNT_W(CW)) u_interleave_seq (
    .clk(clk), .rstN(rstN),
    .cfgPeriod(cfgPeriod), .cfgMaxDuty(cfgMaxDuty),
    .cfgBlank(cfgBlank), .cfgLead(cfgLead),
    .phaseOn(phaseOn), .phaseOff(phaseOff), .blankWin(blankWin),
    .adcTrig(adcTrig), .adcTrigAny(adcTrigAny), .adcChan(adcChan)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int mRun = 0, mCnt = 0, mP = 0, mD = 0, mB = 0, mL = 0, mQ = 0, mChanQ = 0;

  function automatic int relOf(int k);
    int off = k * mQ;
    return (mCnt >= off) ? (mCnt - off) : (mCnt + mP - off);
  endfunction

  function automatic logic [3:0] expTrig();
    logic [3:0] t = '0;
    if (mRun != 0)
      for (int k = 0; k < 4; k++) t[k] = (relOf(k) == mP - mL);
    return t;
  endfunction

  task automatic modelEdge();
    if (!rstN) begin
      mRun = 0; mCnt = 0; mChanQ = 0;
    end else begin
      logic [3:0] t = expTrig();
      for (int k = 3; k >= 0; k--) if (t[k]) mChanQ = k;
      if (mRun == 0 || mCnt == mP - 1) begin
        if (mRun != 0) mCnt = 0;
        mRun = 1;
        mP = int'(cfgPeriod); mD = int'(cfgMaxDuty);
        mB = int'(cfgBlank);  mL = int'(cfgLead);
        mQ = mP / 4;
      end else begin
        mCnt = mCnt + 1;
      end
    end
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [3:0] eOn = '0, eOff = '0, eBl = '0, eTr;
    int eChan = mChanQ;
    eTr = expTrig();
    if (mRun != 0)
      for (int k = 0; k < 4; k++) begin
        eOn[k]  = (relOf(k) == 0);
        eOff[k] = (relOf(k) == mD);
        eBl[k]  = (relOf(k) < mB);
      end
    for (int k = 3; k >= 0; k--) if (eTr[k]) eChan = k;
    chk("R3 phaseOn",    int'(phaseOn),    int'(eOn));
    chk("R4 phaseOff",   int'(phaseOff),   int'(eOff));
    chk("R5 blankWin",   int'(blankWin),   int'(eBl));
    chk("R6 adcTrig",    int'(adcTrig),    int'(eTr));
    chk("R7 adcTrigAny", int'(adcTrigAny), int'(|eTr));
    chk("R8 adcChan",    int'(adcChan),    eChan);
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic setCfg(int p, int d, int b, int l);
    cfgPeriod = CW'(p); cfgMaxDuty = CW'(d);
    cfgBlank  = CW'(b); cfgLead    = CW'(l);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    rstN = 1'b0;
    setCfg(40, 10, 4, 3);
    @(negedge clk);
    repeat (3) tick();
    // R1: reset state
    chk("R1 reset outputs", int'({phaseOn, phaseOff, blankWin, adcTrig, adcTrigAny}), 0);
    chk("R1 reset adcChan", int'(adcChan), 0);
    rstN = 1'b1;
    tick();
    // R1: start with phase 0 on
    chk("R1 start phaseOn", int'(phaseOn), 1);

    for (int v = 0; v < 6; v++) begin
      setCfg(VECS[v].p, VECS[v].d, VECS[v].b, VECS[v].l);
      repeat (VECS[v].n) tick();
    end

    // R10: mid-period change keeps the running period
    setCfg(40, 10, 4, 3);
    repeat (100) tick();
    while (!phaseOn[0]) tick();
    setCfg(24, 10, 4, 3);
    n = 0;
    do begin tick(); n++; end while (!phaseOn[0]);
    chk("R10 period after mid-period change", n, 40);
    n = 0;
    do begin tick(); n++; end while (!phaseOn[0]);
    chk("R2 new period length", n, 24);

    // R9: phase 3 on-time crosses the wrap
    setCfg(40, 35, 4, 3);
    repeat (50) tick();
    while (!phaseOn[3]) tick();
    n = 0;
    do begin tick(); n++; end while (!phaseOff[3]);
    chk("R9 off delay across wrap", n, 35);

    // R1: reset in mid run, then restart
    @(negedge clk);
    rstN = 1'b0;
    tick();
    chk("R1 mid-run reset outputs", int'({phaseOn, phaseOff, blankWin, adcTrig, adcTrigAny}), 0);
    chk("R1 mid-run reset adcChan", int'(adcChan), 0);
    rstN = 1'b1;
    tick();
    chk("R1 restart phaseOn", int'(phaseOn), 1);
    repeat (60) tick();

    summary();
    $finish;
  end
endmodule